// File: doc/BRIEF.md
# Dual-Modulus Swallow Feedback Divider

This block sits in the feedback path of a frequency synthesizer, behind a dual-modulus prescaler that divides the oscillator by either P or P+1. Its clock is the prescaler output, so each clock edge stands for one prescaler pulse. Two down-counters run side by side. The swallow count asks the prescaler for the larger modulus during the first A pulses of each division cycle. After that the prescaler drops back to P for the remaining B−A pulses. The main count sets the cycle length at B pulses. In oscillator periods the cycle therefore lasts A·(P+1) + (B−A)·P = B·P + A. At the end of each cycle one feedback pulse goes to the phase detector.

A new pair of (B, A) settings is written with a one-cycle strobe. Each write is first checked for legality. Legal settings wait in a staging register and reach the counters only at the next cycle boundary, so a running cycle is never cut short or stretched. Illegal settings are refused and reported. The prescaler ratio P never enters the counters, because it only scales the time each pulse represents.

Top module: `swallow_fbdiv`

## Requirements
- R1: While reset is high and right after it, the block runs with B = DEF_B (3) and A = DEF_A (0): `mod_hi` low, `fb_pulse` low, `cfg_bad` low, and each division cycle lasts 3 clocks.
- R2: A division cycle with active setting B lasts exactly B clocks. `fb_pulse` is high for exactly one clock per cycle, on its last clock.
- R3: `mod_hi` (1 = prescaler uses P+1, 0 = prescaler uses P) is high for exactly the first A clocks of each cycle and low for the remaining B−A clocks, never rising again before the cycle ends.
- R4: With A = 0, `mod_hi` stays low for the whole cycle. With A = B, it stays high for the whole cycle.
- R5: A write of `cfg_b`/`cfg_a` with `cfg_wr` high is legal when B ≥ 3 and B ≥ A. A legal write sampled on a clock that is not a cycle's last clock leaves the current cycle unchanged, and the setting governs every cycle from the next one on. `cfg_bad` is low the clock after a legal write.
- R6: When several legal writes fall within one cycle, the last one governs the next cycle.
- R7: A write with B < 3 or B < A raises `cfg_bad` for the one clock after it. It does not change the staged or active settings.
- R8: A legal write sampled on the clock where `fb_pulse` is high does not affect the cycle that starts at that edge. It governs the cycle after that one.
- R9: The full field ranges work: B = 8191 with A = 63 gives a cycle of 8191 clocks with 63 clocks at P+1, and B = A = 3 gives a 3-clock cycle entirely at P+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output pulse, one edge per prescaler pulse |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Strobe: sample `cfg_b`/`cfg_a` this clock |
| cfg_b | input | BW (13) | Main count B, pulses per division cycle |
| cfg_a | input | AW (6) | Swallow count A, pulses at modulus P+1 |
| mod_hi | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| fb_pulse | output | 1 | One-clock feedback pulse on the last clock of each cycle |
| cfg_bad | output | 1 | One-clock flag after an illegal write |

## Verification
The bench keeps the default widths, BW = 13 and AW = 6, and the default reset setting B = 3, A = 0. Each parameter then reaches its extreme value: the longest cycle (8191) with the deepest swallow (63), and the shortest legal cycle of 3 clocks, both fully swallowed and not swallowed at all. With the shortest cycle, a write on the boundary clock, several writes within one cycle and refused writes all fall into a few clocks. This exercises every ordering between staging and reload.

// File: rtl/swfb_pkg.sv
package swfb_pkg;

    // Which half of the division cycle the counters are in.
    typedef enum logic {
        PH_SWALLOW = 1'b1,   // prescaler held at P+1
        PH_MAIN    = 1'b0    // prescaler at P
    } phase_e;

    // A setting is usable when the cycle is long enough and the swallow
    // count fits inside it.
    function automatic logic cfg_legal(input int unsigned b_val,
                                       input int unsigned a_val,
                                       input int unsigned b_floor);
        return (b_val >= b_floor) && (b_val >= a_val);
    endfunction

    function automatic phase_e phase_of(input logic swallow_left);
        return swallow_left ? PH_SWALLOW : PH_MAIN;
    endfunction

endpackage

// File: rtl/swfb_cfg_check.sv
module swfb_cfg_check #(
    parameter int BW    = 13,
    parameter int AW    = 6,
    parameter int B_MIN = 3
) (
    input  logic [BW-1:0] in_b,
    input  logic [AW-1:0] in_a,
    output logic          legal
);
    localparam int unsigned FLOOR = B_MIN;

    always_comb begin
        legal = swfb_pkg::cfg_legal(32'(in_b), 32'(in_a), FLOOR);
    end
endmodule

// File: rtl/swfb_cfg_stage.sv
module swfb_cfg_stage #(
    parameter int BW    = 13,
    parameter int AW    = 6,
    parameter int DEF_B = 3,
    parameter int DEF_A = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic          legal,
    input  logic [BW-1:0] in_b,
    input  logic [AW-1:0] in_a,
    input  logic          boundary,
    output logic [BW-1:0] load_b,
    output logic [AW-1:0] load_a,
    output logic          bad
);
    logic [BW-1:0] act_b, pend_b;
    logic [AW-1:0] act_a, pend_a;
    logic          pend_vld;

    // The next cycle takes the staged setting if one is waiting, else it
    // repeats the active one.
    always_comb begin
        load_b = pend_vld ? pend_b : act_b;
        load_a = pend_vld ? pend_a : act_a;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_b    <= BW'(DEF_B);
            act_a    <= AW'(DEF_A);
            pend_b   <= BW'(DEF_B);
            pend_a   <= AW'(DEF_A);
            pend_vld <= 1'b0;
            bad      <= 1'b0;
        end else begin
            bad <= wr && !legal;
            if (boundary) begin
                act_b <= load_b;
                act_a <= load_a;
            end
            // A legal write always lands in staging; the reload above
            // has already used the old staging value on this edge.
            if (wr && legal) begin
                pend_b   <= in_b;
                pend_a   <= in_a;
                pend_vld <= 1'b1;
            end else if (boundary) begin
                pend_vld <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/swfb_swallow_cnt.sv
module swfb_swallow_cnt #(
    parameter int BW    = 13,
    parameter int AW    = 6,
    parameter int DEF_B = 3,
    parameter int DEF_A = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] load_b,
    input  logic [AW-1:0] load_a,
    output logic          terminal,
    output logic          mod_hi,
    output logic [BW-1:0] b_left,
    output logic [AW-1:0] a_left
);
    import swfb_pkg::*;

    localparam logic [BW-1:0] B_ONE = BW'(1);
    localparam logic [AW-1:0] A_ONE = AW'(1);

    logic [BW-1:0] b_q;
    logic [AW-1:0] a_q;
    phase_e        phase;

    always_comb begin
        terminal = (b_q == B_ONE);
        phase    = phase_of(a_q != '0);
        mod_hi   = (phase == PH_SWALLOW);
        b_left   = b_q;
        a_left   = a_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= BW'(DEF_B);
            a_q <= AW'(DEF_A);
        end else if (terminal) begin
            b_q <= load_b;
            a_q <= load_a;
        end else begin
            b_q <= b_q - B_ONE;
            if (phase == PH_SWALLOW) begin
                a_q <= a_q - A_ONE;
            end
        end
    end
endmodule

// File: rtl/swallow_fbdiv.sv
module swallow_fbdiv #(
    parameter int BW    = 13,
    parameter int AW    = 6,
    parameter int B_MIN = 3,
    parameter int DEF_B = 3,
    parameter int DEF_A = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_wr,
    input  logic [BW-1:0] cfg_b,
    input  logic [AW-1:0] cfg_a,
    output logic          mod_hi,
    output logic          fb_pulse,
    output logic          cfg_bad
);
    logic          wr_legal;
    logic          boundary;
    logic [BW-1:0] next_b;
    logic [AW-1:0] next_a;
    logic [BW-1:0] cnt_b;
    logic [AW-1:0] cnt_a;

    swfb_cfg_check #(.BW(BW), .AW(AW), .B_MIN(B_MIN)) u_check (
        .in_b  (cfg_b),
        .in_a  (cfg_a),
        .legal (wr_legal)
    );

    swfb_cfg_stage #(.BW(BW), .AW(AW), .DEF_B(DEF_B), .DEF_A(DEF_A)) u_stage (
        .clk      (clk),
        .rst      (rst),
        .wr       (cfg_wr),
        .legal    (wr_legal),
        .in_b     (cfg_b),
        .in_a     (cfg_a),
        .boundary (boundary),
        .load_b   (next_b),
        .load_a   (next_a),
        .bad      (cfg_bad)
    );

    swfb_swallow_cnt #(.BW(BW), .AW(AW), .DEF_B(DEF_B), .DEF_A(DEF_A)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load_b   (next_b),
        .load_a   (next_a),
        .terminal (boundary),
        .mod_hi   (mod_hi),
        .b_left   (cnt_b),
        .a_left   (cnt_a)
    );

    assign fb_pulse = boundary;
endmodule

// File: rtl/swfb_checker.sv
module swfb_checker #(
    parameter int BW    = 13,
    parameter int AW    = 6,
    parameter int B_MIN = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic [BW-1:0] cfg_b,
    input logic [AW-1:0] cfg_a,
    input logic          mod_hi,
    input logic          fb_pulse,
    input logic          cfg_bad,
    input logic [BW-1:0] cnt_b,
    input logic [AW-1:0] cnt_a
);
    localparam logic [BW-1:0] FLOOR = BW'(B_MIN);

    // R2: the feedback pulse never lasts two clocks
    assert_fb_single_R2: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> !fb_pulse);

    // R2: a reload always starts a cycle of legal length
    assert_reload_len_R2: assert property (@(posedge clk) disable iff (rst)
        fb_pulse |=> (cnt_b >= FLOOR));

    // R3: once the prescaler is released to P it stays there until the boundary
    assert_release_sticky_R3: assert property (@(posedge clk) disable iff (rst)
        (!mod_hi && !fb_pulse) |=> !mod_hi);

    // R3: the swallow count never outlasts the main count
    assert_swallow_fits_R3: assert property (@(posedge clk) disable iff (rst)
        {{(BW-AW){1'b0}}, cnt_a} <= cnt_b);

    // R7: a refused write is flagged on the next clock
    assert_bad_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && ((cfg_b < FLOOR) || (cfg_b < {{(BW-AW){1'b0}}, cfg_a}))) |=> cfg_bad);

    // R5: an accepted write or no write leaves the flag low
    assert_no_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wr || ((cfg_b >= FLOOR) && (cfg_b >= {{(BW-AW){1'b0}}, cfg_a}))) |=> !cfg_bad);
endmodule

bind swallow_fbdiv swfb_checker #(.BW(BW), .AW(AW), .B_MIN(B_MIN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_wr   (cfg_wr),
    .cfg_b    (cfg_b),
    .cfg_a    (cfg_a),
    .mod_hi   (mod_hi),
    .fb_pulse (fb_pulse),
    .cfg_bad  (cfg_bad),
    .cnt_b    (cnt_b),
    .cnt_a    (cnt_a)
);

// File: tb/swallow_fbdiv_bench.sv
module swallow_fbdiv_bench;
    localparam int BW = 13;
    localparam int AW = 6;

    typedef struct {
        int b;
        int a;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [BW-1:0] cfg_b = '0;
    logic [AW-1:0] cfg_a = '0;
    logic          mod_hi, fb_pulse, cfg_bad;

    swallow_fbdiv #(.BW(BW), .AW(AW)) u_swallow_fbdiv (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_b(cfg_b), .cfg_a(cfg_a),
        .mod_hi(mod_hi), .fb_pulse(fb_pulse), .cfg_bad(cfg_bad)
    );

    always #2 clk = ~clk;

    int   checks = 0, errors = 0;
    int   cycles_done = 0;
    int   len = 0, hi = 0, last_len = 0, last_hi = 0;
    bit   released = 0, order_bad = 0;
    exp_t cfg_q[$];
    exp_t cur_exp = '{3, 0};

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Monitor: one sample per prescaler pulse, scored at each cycle end.
    always @(negedge clk) begin
        if (rst) begin
            len = 0; hi = 0; released = 0; order_bad = 0;
        end else begin
            len++;
            if (mod_hi) begin
                hi++;
                if (released) order_bad = 1;
            end else begin
                released = 1;
            end
            if (fb_pulse) begin
                check(len == cur_exp.b,
                      (cycles_done == 0) ? "R1" : (cur_exp.b == 8191) ? "R9" : "R2",
                      "cycle length", len, cur_exp.b);
                check(hi == cur_exp.a,
                      (cur_exp.a == 63) ? "R9" :
                      (cur_exp.a == 0 || cur_exp.a == cur_exp.b) ? "R4" : "R3",
                      "clocks at P+1", hi, cur_exp.a);
                check(!order_bad, "R3", "P+1 clocks lead the cycle", order_bad, 0);
                if (cfg_q.size() > 0) begin
                    cur_exp = cfg_q[$];   // R6: newest staged setting wins
                    cfg_q.delete();
                end
                last_len = len; last_hi = hi;
                len = 0; hi = 0; released = 0; order_bad = 0;
                cycles_done++;
            end
        end
    end

    // Driver: one write sampled on the given clock, scoreboard fed after it.
    task automatic drive_one(input int b, input int a, input bit legal);
        cfg_b  = BW'(b);
        cfg_a  = AW'(a);
        cfg_wr = 1'b1;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
        if (legal) begin
            cfg_q.push_back('{b, a});
            check(cfg_bad == 1'b0, "R5", "flag after legal write", cfg_bad, 0);
        end else begin
            check(cfg_bad == 1'b1, "R7", "flag after illegal write", cfg_bad, 1);
        end
    endtask

    task automatic wait_fb();
        do @(negedge clk); while (!fb_pulse);
    endtask

    // Write on the first clock of a cycle, well clear of its boundary.
    task automatic write_mid(input int b, input int a, input bit legal);
        wait_fb();
        @(posedge clk);
        #1;
        drive_one(b, a, legal);
    endtask

    task automatic run_cycles(input int k);
        int n;
        n = cycles_done;
        wait (cycles_done >= n + k);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(mod_hi == 1'b0, "R1", "mod_hi in reset", mod_hi, 0);
        check(fb_pulse == 1'b0, "R1", "fb_pulse in reset", fb_pulse, 0);
        check(cfg_bad == 1'b0, "R1", "cfg_bad in reset", cfg_bad, 0);
        @(posedge clk);
        #1 rst = 1'b0;
        run_cycles(2);

        // R5: current cycle keeps the old setting, the next uses the new one
        write_mid(10, 4, 1);
        n = cycles_done;
        wait (cycles_done == n + 1);
        check(last_len == 3, "R5", "cycle in flight unchanged", last_len, 3);
        wait (cycles_done == n + 2);
        check(last_len == 10 && last_hi == 4, "R5", "new setting length", last_len, 10);
        run_cycles(1);

        write_mid(20, 0, 1);   // R4: A = 0
        run_cycles(3);
        write_mid(7, 7, 1);    // R4: A = B
        run_cycles(3);

        // R7: refused writes leave (7,7) in force
        write_mid(5, 6, 0);
        write_mid(2, 0, 0);
        n = cycles_done;
        wait (cycles_done == n + 2);
        check(last_len == 7 && last_hi == 7, "R7", "setting kept after refusal", last_len, 7);

        // R6: two writes inside one cycle, the second one wins
        wait_fb();
        @(posedge clk);
        #1;
        drive_one(12, 3, 1);
        drive_one(9, 2, 1);
        n = cycles_done;
        wait (cycles_done == n + 2);
        check(last_len == 9 && last_hi == 2, "R6", "last write wins", last_len, 9);

        // R8: write sampled on the boundary clock skips one cycle
        wait_fb();
        #1;
        n = cycles_done;
        drive_one(15, 5, 1);
        wait (cycles_done == n + 1);
        check(last_len == 9, "R8", "cycle after boundary write still old", last_len, 9);
        wait (cycles_done == n + 2);
        check(last_len == 15 && last_hi == 5, "R8", "boundary write applied later", last_len, 15);

        // R9: field extremes
        write_mid(8191, 63, 1);
        run_cycles(2);
        write_mid(3, 3, 1);
        run_cycles(3);
        check(last_len == 3 && last_hi == 3, "R9", "shortest fully swallowed cycle", last_hi, 3);
        write_mid(3, 0, 1);
        run_cycles(3);

        check(cfg_q.size() == 0, "R5", "all staged settings consumed", cfg_q.size(), 0);
        check(cycles_done >= 20, "R2", "cycles observed", cycles_done, 20);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule